// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block holds the error status for the two halves of a data buffer. An ECC checker reports, per half, a correctable-error strobe, an uncorrectable-error strobe and an 8-bit syndrome. Each half has one 64-bit status register. The register keeps a sticky flag for each error class. It also keeps the syndrome of the error that matters most: the first correctable error, or an uncorrectable error that arrives later and replaces it.

Software reaches both registers over a simple register bus. Reads and writes use separate address-space identifiers. A read returns a register's value in the cycle after the read strobe and does not change the register. Software clears a flag by writing a 1 to its bit. If an error event arrives in the same cycle as the clear, the flag stays set, so no event is lost. An error-pending output is high while any flag in either half is set, and can raise an interrupt.

Top module: `eccst_capture`

## Requirements
- R1: After reset both registers read as zero, `rdata_o` is zero and `err_pend_o` is low.
- R2: Read data layout: bit 9 is the uncorrectable flag, bit 8 is the correctable flag, bits 7:0 are the syndrome, and bits 63:10 read as zero. `rdata_o` carries the value from before the read edge in the cycle after a read strobe. In every other cycle it is zero.
- R3: Reads are served only with identifier 0x7F and writes only with identifier 0x77. The upper-half register is at address 0x0 and the lower-half register is at address 0x18.
- R4: An error strobe sets its flag in the matching half at the next edge. The flag then stays set until it is cleared.
- R5: A write with bit 8 or bit 9 of the write data at 1 clears the matching flag. A 0 in either bit leaves the flag unchanged, and write data bits 7:0 never change the syndrome.
- R6: An error strobe in the same cycle as a clear of its flag leaves the flag set.
- R7: The syndrome is loaded on a correctable event only while both flags are clear. Later correctable events leave it unchanged.
- R8: The syndrome is loaded on an uncorrectable event whenever the uncorrectable flag is clear, so it replaces a captured correctable syndrome. It then holds while the uncorrectable flag is set.
- R9: A read leaves both registers unchanged.
- R10: `err_pend_o` is high exactly while at least one flag in either half is set.
- R11: An access with an unmatched identifier or address has no effect on any register, and a read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_evt_i | input | 2 | Correctable-error strobe per half (bit 0 upper, bit 1 lower) |
| ue_evt_i | input | 2 | Uncorrectable-error strobe per half |
| syn_i | input | 16 | Syndrome per half (7:0 upper, 15:8 lower) |
| asi_i | input | 8 | Address-space identifier of the access |
| addr_i | input | 64 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid in the cycle after a read |
| err_pend_o | output | 1 | Any flag set in either half |

## Verification
Directed sequences separate the syndrome policies from each other. Repeated correctable events with different syndromes show whether the first one is kept. A later uncorrectable event shows whether it takes over the syndrome. An event in the same cycle as its clear shows whether the set wins. Writes that carry only syndrome bits, or that use the read identifier or a stray address, show whether the register holds its state. Random traffic mixes events in both halves with reads and writes over matched and unmatched identifiers and addresses. It is checked every cycle against a bench model, which exposes any cross-talk between halves and any loss of state between the sticky flags and the clears.

// File: rtl/eccst_pkg.sv
package eccst_pkg;
  localparam int SYN_W    = 8;
  localparam int CE_BIT   = 8;
  localparam int UE_BIT   = 9;
  localparam int STAT_W   = UE_BIT + 1;
  localparam int NUM_HALF = 2;
  localparam int HALF_UP  = 0;
  localparam int HALF_LO  = 1;

  typedef struct packed {
    logic             ue;
    logic             ce;
    logic [SYN_W-1:0] syn;
  } err_stat_t;
endpackage

// File: rtl/eccst_decode.sv
module eccst_decode
  import eccst_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter int                ASI_W   = 8,
  parameter logic [ASI_W-1:0]  WR_ASI  = 8'h77,
  parameter logic [ASI_W-1:0]  RD_ASI  = 8'h7F,
  parameter logic [ADDR_W-1:0] UP_ADDR = '0,
  parameter logic [ADDR_W-1:0] LO_ADDR = 64'h18
) (
  input  logic [ASI_W-1:0]    asi_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  output logic [NUM_HALF-1:0] rd_hit_o,
  output logic [NUM_HALF-1:0] wr_hit_o
);
  logic rd_asi_ok, wr_asi_ok;
  assign rd_asi_ok = rd_i && (asi_i == RD_ASI);
  assign wr_asi_ok = wr_i && (asi_i == WR_ASI);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HADDR = (h == HALF_UP) ? UP_ADDR : LO_ADDR;
    logic addr_ok;
    assign addr_ok     = (addr_i == HADDR);
    assign rd_hit_o[h] = rd_asi_ok && addr_ok;
    assign wr_hit_o[h] = wr_asi_ok && addr_ok;
  end
endmodule

// File: rtl/eccst_half.sv
module eccst_half
  import eccst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_evt_i,
  input  logic             ue_evt_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             clr_ce_i,
  input  logic             clr_ue_i,
  output err_stat_t        stat_o
);
  err_stat_t q, d;
  logic      load_syn;

  // UE may replace a CE syndrome; CE captures only into an idle register
  assign load_syn = (ue_evt_i && !q.ue) || (ce_evt_i && !q.ce && !q.ue);

  always_comb begin
    d     = q;
    d.ce  = ce_evt_i || (q.ce && !clr_ce_i);
    d.ue  = ue_evt_i || (q.ue && !clr_ue_i);
    if (load_syn) d.syn = syn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign stat_o = q;
endmodule

// File: rtl/eccst_rdmux.sv
module eccst_rdmux
  import eccst_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_HALF-1:0] rd_hit_i,
  input  err_stat_t           stat_i [NUM_HALF],
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    for (int h = 0; h < NUM_HALF; h++)
      if (rd_hit_i[h]) sel = sel | stat_i[h];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= {{PAD_W{1'b0}}, sel};
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/eccst_capture.sv
module eccst_capture
  import eccst_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter int                DATA_W  = 64,
  parameter int                ASI_W   = 8,
  parameter logic [ASI_W-1:0]  WR_ASI  = 8'h77,
  parameter logic [ASI_W-1:0]  RD_ASI  = 8'h7F,
  parameter logic [ADDR_W-1:0] UP_ADDR = '0,
  parameter logic [ADDR_W-1:0] LO_ADDR = 64'h18
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_HALF-1:0]       ce_evt_i,
  input  logic [NUM_HALF-1:0]       ue_evt_i,
  input  logic [NUM_HALF*SYN_W-1:0] syn_i,
  input  logic [ASI_W-1:0]          asi_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      err_pend_o
);
  logic [NUM_HALF-1:0]       rd_hit, wr_hit;
  err_stat_t                 stat [NUM_HALF];
  logic [NUM_HALF-1:0]       ce_q, ue_q;
  logic [NUM_HALF*SYN_W-1:0] syn_q;
  logic                      unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:UE_BIT+1], wdata_i[CE_BIT-1:0]};

  eccst_decode #(
    .ADDR_W(ADDR_W), .ASI_W(ASI_W), .WR_ASI(WR_ASI), .RD_ASI(RD_ASI),
    .UP_ADDR(UP_ADDR), .LO_ADDR(LO_ADDR)
  ) u_decode (
    .asi_i   (asi_i),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .rd_hit_o(rd_hit),
    .wr_hit_o(wr_hit)
  );

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    eccst_half u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ce_evt_i(ce_evt_i[h]),
      .ue_evt_i(ue_evt_i[h]),
      .syn_i   (syn_i[h*SYN_W +: SYN_W]),
      .clr_ce_i(wr_hit[h] && wdata_i[CE_BIT]),
      .clr_ue_i(wr_hit[h] && wdata_i[UE_BIT]),
      .stat_o  (stat[h])
    );
    assign ce_q[h]                  = stat[h].ce;
    assign ue_q[h]                  = stat[h].ue;
    assign syn_q[h*SYN_W +: SYN_W]  = stat[h].syn;
  end

  eccst_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hit_i(rd_hit),
    .stat_i  (stat),
    .rdata_o (rdata_o)
  );

  assign err_pend_o = |{ce_q, ue_q};
endmodule

// File: rtl/eccst_capture_chk.sv
module eccst_capture_chk
  import eccst_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter int                DATA_W  = 64,
  parameter int                ASI_W   = 8,
  parameter logic [ASI_W-1:0]  WR_ASI  = 8'h77,
  parameter logic [ADDR_W-1:0] UP_ADDR = '0,
  parameter logic [ADDR_W-1:0] LO_ADDR = 64'h18
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_HALF-1:0]       ce_evt_i,
  input logic [NUM_HALF-1:0]       ue_evt_i,
  input logic [ASI_W-1:0]          asi_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      rd_i,
  input logic                      wr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic                      err_pend_o,
  input logic [NUM_HALF-1:0]       ce_q,
  input logic [NUM_HALF-1:0]       ue_q,
  input logic [NUM_HALF*SYN_W-1:0] syn_q
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:STAT_W] == '0); // R2

  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0); // R2

  AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_pend_o) |-> $past(|{ce_evt_i, ue_evt_i})); // R10

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_chk
    localparam logic [ADDR_W-1:0] HADDR = (h == HALF_UP) ? UP_ADDR : LO_ADDR;
    logic wr_here;
    assign wr_here = wr_i && (asi_i == WR_ASI) && (addr_i == HADDR);

    AST_CE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_evt_i[h] |=> ce_q[h]); // R6
    AST_UE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ue_evt_i[h] |=> ue_q[h]); // R4
    AST_CE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_q[h] && !(wr_here && wdata_i[CE_BIT]) |=> ce_q[h]); // R4
    AST_CE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_q[h] && wr_here && wdata_i[CE_BIT] && !ce_evt_i[h] |=> !ce_q[h]); // R5
    AST_UE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ue_q[h] && wr_here && wdata_i[UE_BIT] && !ue_evt_i[h] |=> !ue_q[h]); // R5
    AST_SYN_UE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ue_q[h] |=> $stable(syn_q[h*SYN_W +: SYN_W])); // R8
    AST_SYN_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_q[h] && !ue_evt_i[h] |=> $stable(syn_q[h*SYN_W +: SYN_W])); // R7
  end
endmodule

bind eccst_capture eccst_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASI_W(ASI_W), .WR_ASI(WR_ASI),
  .UP_ADDR(UP_ADDR), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_evt_i  (ce_evt_i),
  .ue_evt_i  (ue_evt_i),
  .asi_i     (asi_i),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .err_pend_o(err_pend_o),
  .ce_q      (ce_q),
  .ue_q      (ue_q),
  .syn_q     (syn_q)
);

// File: tb/eccst_capture_bench.sv
module eccst_capture_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  RAND_CYC   = 3000;
  localparam logic [7:0]  A_WR = 8'h77;
  localparam logic [7:0]  A_RD = 8'h7F;
  localparam logic [63:0] AD_UP = 64'h0;
  localparam logic [63:0] AD_LO = 64'h18;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ce_evt_i = '0, ue_evt_i = '0;
  logic [15:0] syn_i = '0;
  logic [7:0]  asi_i = '0;
  logic [63:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        err_pend_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       m_ce [2];
  logic       m_ue [2];
  logic [7:0] m_syn [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  eccst_capture u_eccst_capture (
    .clk_i(clk), .rst_ni(rst_ni), .ce_evt_i(ce_evt_i), .ue_evt_i(ue_evt_i),
    .syn_i(syn_i), .asi_i(asi_i), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .err_pend_o(err_pend_o)
  );

  function automatic logic [63:0] reg_val(int h);
    return {54'b0, m_ue[h], m_ce[h], m_syn[h]};
  endfunction

  function automatic int half_of(logic [63:0] a);
    if (a == AD_UP) return 0;
    if (a == AD_LO) return 1;
    return -1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, model the edge, check at next negedge
  task automatic cyc(string tag, logic [1:0] ce, logic [1:0] ue, logic [15:0] syn,
                     logic [7:0] asi, logic [63:0] addr, logic rd, logic wr,
                     logic [63:0] wd);
    logic [63:0] exp_rd;
    int hh;
    ce_evt_i = ce; ue_evt_i = ue; syn_i = syn;
    asi_i = asi; addr_i = addr; rd_i = rd; wr_i = wr; wdata_i = wd;
    hh = half_of(addr);
    exp_rd = (rd && asi == A_RD && hh >= 0) ? reg_val(hh) : 64'h0;
    for (int h = 0; h < 2; h++) begin
      logic whit, load;
      whit = wr && asi == A_WR && hh == h;
      load = (ue[h] && !m_ue[h]) || (ce[h] && !m_ce[h] && !m_ue[h]);
      if (load) m_syn[h] = syn[h*8 +: 8];
      m_ce[h] = ce[h] || (m_ce[h] && !(whit && wd[8]));
      m_ue[h] = ue[h] || (m_ue[h] && !(whit && wd[9]));
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rdata"}, rdata_o, exp_rd);
    check("R10 pend", {63'b0, err_pend_o},
          {63'b0, m_ce[0] | m_ue[0] | m_ce[1] | m_ue[1]});
    ce_evt_i = '0; ue_evt_i = '0; rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic idle(string tag);
    cyc(tag, 2'b00, 2'b00, 16'h0, 8'h0, 64'h0, 1'b0, 1'b0, 64'h0);
  endtask

  task automatic rd(string tag, logic [63:0] addr);
    cyc(tag, 2'b00, 2'b00, 16'h0, A_RD, addr, 1'b1, 1'b0, 64'h0);
  endtask

  task automatic wr(string tag, logic [7:0] asi, logic [63:0] addr, logic [63:0] wd);
    cyc(tag, 2'b00, 2'b00, 16'h0, asi, addr, 1'b0, 1'b1, wd);
  endtask

  initial begin
    for (int h = 0; h < 2; h++) begin m_ce[h] = 0; m_ue[h] = 0; m_syn[h] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata_o, 64'h0);
    check("R1 reset pend", {63'b0, err_pend_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd("R1 read upper after reset", AD_UP);
    rd("R1 read lower after reset", AD_LO);

    // first CE captured, later CE keeps syndrome
    cyc("R4 ce upper", 2'b01, 2'b00, 16'h00A5, 8'h0, 64'h0, 0, 0, 64'h0);
    cyc("R7 second ce upper", 2'b01, 2'b00, 16'h003C, 8'h0, 64'h0, 0, 0, 64'h0);
    rd("R7 R2 upper syn first ce", AD_UP);
    rd("R9 repeat read", AD_UP);
    rd("R3 lower untouched", AD_LO);
    // UE replaces CE syndrome, then holds
    cyc("R8 ue upper", 2'b00, 2'b01, 16'h00E1, 8'h0, 64'h0, 0, 0, 64'h0);
    cyc("R8 second ue", 2'b00, 2'b01, 16'h0011, 8'h0, 64'h0, 0, 0, 64'h0);
    rd("R8 upper ue syndrome", AD_UP);
    // syndrome bits and zero flag bits in write data ignored
    wr("R5 syn write ignored", A_WR, AD_UP, 64'hFFFF_FFFF_FFFF_FCFF);
    rd("R5 after syn write", AD_UP);
    // wrong identifier / address writes
    wr("R3 write on read asi", A_RD, AD_UP, 64'h300);
    wr("R11 write bad asi", 8'h12, AD_UP, 64'h300);
    wr("R11 write bad addr", A_WR, 64'h8, 64'h300);
    rd("R11 state kept", AD_UP);
    cyc("R11 read bad asi", 2'b00, 2'b00, 16'h0, A_WR, AD_UP, 1, 0, 64'h0);
    cyc("R11 read bad addr", 2'b00, 2'b00, 16'h0, A_RD, 64'h10, 1, 0, 64'h0);
    // clear CE only
    wr("R5 clear ce", A_WR, AD_UP, 64'h100);
    rd("R5 ce cleared ue kept", AD_UP);
    // set wins over clear
    cyc("R6 ue with clear", 2'b00, 2'b01, 16'h0077, A_WR, AD_UP, 0, 1, 64'h200);
    rd("R6 ue still set", AD_UP);
    wr("R5 clear ue", A_WR, AD_UP, 64'h200);
    rd("R5 upper clear", AD_UP);
    // lower half, then new capture after clear
    cyc("R3 ce lower", 2'b10, 2'b00, 16'h5A00, 8'h0, 64'h0, 0, 0, 64'h0);
    rd("R3 lower syn", AD_LO);
    cyc("R6 ce with clear lower", 2'b10, 2'b00, 16'h6600, A_WR, AD_LO, 0, 1, 64'h100);
    rd("R6 lower ce kept", AD_LO);
    wr("R5 clear lower", A_WR, AD_LO, 64'h300);
    cyc("R7 new capture", 2'b10, 2'b00, 16'h4200, 8'h0, 64'h0, 0, 0, 64'h0);
    rd("R7 lower new syn", AD_LO);
    wr("R5 clear lower", A_WR, AD_LO, 64'h300);
    idle("R10 idle");

    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < RAND_CYC; i++) begin
      logic [1:0] ce, ue;
      logic [7:0] asi;
      logic [63:0] addr, wd;
      int s;
      ce[0] = ($urandom % 8) == 0; ce[1] = ($urandom % 8) == 0;
      ue[0] = ($urandom % 16) == 0; ue[1] = ($urandom % 16) == 0;
      s = $urandom % 3;
      asi = (s == 0) ? A_WR : (s == 1) ? A_RD : 8'($urandom);
      s = $urandom % 5;
      addr = (s < 2) ? AD_UP : (s < 4) ? AD_LO : {32'($urandom), 32'($urandom)};
      wd = {32'($urandom), 32'($urandom)};
      cyc("R2 R4 R5 R6 R7 R8 R11 random", ce, ue, 16'($urandom), asi, addr,
          1'($urandom), 1'($urandom), wd);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule